// File: doc/BRIEF.md
# Windowed Integer Register File

This block holds the integer registers of a processor core whose procedure calls shift a window over a larger physical store. Software always sees 32 logical registers, numbered 0 to 31 on 5 bits. Numbers 0–7 are global, 8–15 are the outs, 16–23 are the locals and 24–31 are the ins. The globals come in two banks, and a plain select input picks the bank. The other 24 names map through a current window pointer into a ring of physical windows. Each ring entry holds 16 registers: 8 ins and 8 locals. The outs of a window are the ins of the window one step below it in the ring. After a save, the caller's outs therefore appear as the callee's ins.

Two asynchronous reads and one synchronous write are served each cycle. A call input uses the write port to store its instruction address into logical register 15 of the current window. Save and restore commands move the pointer one step. The block keeps count of the windows in use. When a save would overwrite live state, or a restore would climb above the first window, the block raises a one-cycle flag and leaves the pointer where it is. Spilling and filling windows in memory are left to the surrounding core.

Top module: `rwin_regfile`

## Requirements
- R1: A read of logical register 0 returns zero on both read ports with either global bank selected. A write to register 0, from either bank, changes no register.
- R2: Registers 1–7 in the two global banks are independent. With `alt_glb`=1, the bank seen by reads and writes is the alternate one. With `alt_glb`=0, it is the normal one.
- R3: A read of the register being written in the same cycle returns the old value. The new value is readable from the cycle after the write edge.
- R4: After reset the window pointer is 0. An accepted save lowers it by one modulo `NWIN`, so a save from 0 gives `NWIN`-1. An accepted restore raises it by one modulo `NWIN`. The new pointer shows on `cwp_o` after the edge that takes the command.
- R5: After an accepted save, logical register 24+i reads the value that logical register 8+i held before the save. After the matching restore, logical register 8+i reads what the callee last wrote to 24+i.
- R6: Locals (16–23) are private to each window. A new window does not show the caller's locals, and a restore brings the caller's locals back unchanged.
- R7: With `call_en`=1, `call_pc` is written into logical register 15 of the current window at the next edge. Any `wr_en` request in that cycle is ignored.
- R8: While `NWIN`-2 saves are outstanding, a further save is refused. `ovf_o` is 1 for exactly the one cycle after the edge that refused the save, and the pointer stays put.
- R9: While no save is outstanding, a restore is refused. `unf_o` is 1 for exactly the one cycle after the edge that refused the restore, and the pointer stays put.
- R10: A cycle with both `save_req` and `restore_req` at 1 moves nothing and raises no flag.
- R11: A register write issued in the same cycle as a save lands in the window that was current before the move.
- R12: After reset, every register reads zero and both flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_a_idx | input | 5 | Logical register number, read port A |
| rd_a_data | output | XLEN | Read data, port A (combinational) |
| rd_b_idx | input | 5 | Logical register number, read port B |
| rd_b_data | output | XLEN | Read data, port B (combinational) |
| wr_en | input | 1 | Write request |
| wr_idx | input | 5 | Logical register number to write |
| wr_data | input | XLEN | Write data |
| call_en | input | 1 | Call: store `call_pc` into logical register 15 |
| call_pc | input | XLEN | Address of the call instruction |
| save_req | input | 1 | Move to a fresh window |
| restore_req | input | 1 | Return to the caller's window |
| alt_glb | input | 1 | Select the alternate global bank |
| cwp_o | output | $clog2(NWIN) | Current window pointer |
| ovf_o | output | 1 | One-cycle pulse: save refused |
| unf_o | output | 1 | One-cycle pulse: restore refused |

## Verification
Read data depends on the index, the pointer and the bank select with no register in between. The bench therefore checks a read 1 ns after it changes the index, in the same cycle. Writes, calls and window commands are committed by one clock edge. Their results, meaning the new register contents, the new `cwp_o` and the `ovf_o`/`unf_o` pulses, are sampled 1 ns after that edge. The pulses are sampled again one edge later to confirm they last a single cycle. For the read-during-write case, the bench holds the write request and checks the read port before the edge, then checks it again after the edge.

// File: rtl/rwf_pkg.sv
package rwf_pkg;

  // Logical register groups, selected by the upper two index bits.
  typedef enum logic [1:0] {
    GRP_GLB = 2'b00,
    GRP_OUT = 2'b01,
    GRP_LOC = 2'b10,
    GRP_IN  = 2'b11
  } reg_grp_e;

  // Window command decoded from the save/restore inputs.
  typedef enum logic [1:0] {
    WCMD_NONE,
    WCMD_SAVE,
    WCMD_RESTORE,
    WCMD_CLASH
  } win_cmd_e;

  localparam int GLB_REGS  = 8;
  localparam int SET_REGS  = 16;
  localparam logic [4:0] LINK_IDX = 5'd15;

  function automatic win_cmd_e decode_cmd(input logic sv, input logic rs);
    case ({sv, rs})
      2'b10:   return WCMD_SAVE;
      2'b01:   return WCMD_RESTORE;
      2'b11:   return WCMD_CLASH;
      default: return WCMD_NONE;
    endcase
  endfunction

endpackage

// File: rtl/rwf_window_ctrl.sv
module rwf_window_ctrl
  import rwf_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int CW   = $clog2(NWIN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          save_req,
  input  logic          restore_req,
  output logic [CW-1:0] cwp,
  output logic [CW-1:0] depth,
  output logic          ovf,
  output logic          unf
);

  localparam logic [CW-1:0] LAST     = CW'(NWIN - 1);
  localparam logic [CW-1:0] SAVE_MAX = CW'(NWIN - 2);

  win_cmd_e      cmd;
  logic          can_save;
  logic          can_restore;
  logic [CW-1:0] cwp_dn;
  logic [CW-1:0] cwp_up;

  always_comb begin
    cmd         = decode_cmd(save_req, restore_req);
    can_save    = (depth < SAVE_MAX);
    can_restore = (depth != '0);
    cwp_dn      = (cwp == '0) ? LAST : cwp - 1'b1;
    cwp_up      = (cwp == LAST) ? '0 : cwp + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cwp   <= '0;
      depth <= '0;
      ovf   <= 1'b0;
      unf   <= 1'b0;
    end else begin
      ovf <= 1'b0;
      unf <= 1'b0;
      case (cmd)
        WCMD_SAVE: begin
          if (can_save) begin
            cwp   <= cwp_dn;
            depth <= depth + 1'b1;
          end else begin
            ovf <= 1'b1;
          end
        end
        WCMD_RESTORE: begin
          if (can_restore) begin
            cwp   <= cwp_up;
            depth <= depth - 1'b1;
          end else begin
            unf <= 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/rwf_addr_map.sv
module rwf_addr_map
  import rwf_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int CW   = $clog2(NWIN),
  parameter int PW   = $clog2(2 * GLB_REGS + SET_REGS * NWIN)
) (
  input  logic [4:0]    lidx,
  input  logic [CW-1:0] cwp,
  input  logic          alt,
  output logic [PW-1:0] pidx,
  output logic          is_zero
);

  localparam logic [CW-1:0] LAST  = CW'(NWIN - 1);
  localparam logic [PW-1:0] WBASE = PW'(2 * GLB_REGS);

  reg_grp_e      grp;
  logic [2:0]    slot;
  logic [CW-1:0] below;

  always_comb begin
    grp     = reg_grp_e'(lidx[4:3]);
    slot    = lidx[2:0];
    below   = (cwp == '0) ? LAST : cwp - 1'b1;
    is_zero = (lidx == 5'd0);
    // Each ring entry: ins at offset 0..7, locals at offset 8..15.
    case (grp)
      GRP_GLB: pidx = PW'({alt, slot});
      GRP_OUT: pidx = WBASE + PW'({below, 1'b0, slot});
      GRP_LOC: pidx = WBASE + PW'({cwp, 1'b1, slot});
      default: pidx = WBASE + PW'({cwp, 1'b0, slot});
    endcase
  end

endmodule

// File: rtl/rwf_storage.sv
module rwf_storage #(
  parameter int XLEN = 64,
  parameter int PHYS = 144,
  parameter int PW   = $clog2(PHYS),
  parameter int NRD  = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we,
  input  logic [PW-1:0]             waddr,
  input  logic [XLEN-1:0]           wdata,
  input  logic [NRD-1:0][PW-1:0]    raddr,
  output logic [NRD-1:0][XLEN-1:0]  rdata
);

  logic [XLEN-1:0] mem [PHYS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < PHYS; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rdata[g] = mem[raddr[g]];
  end

endmodule

// File: rtl/rwin_regfile.sv
module rwin_regfile
  import rwf_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int NWIN = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [4:0]               rd_a_idx,
  output logic [XLEN-1:0]          rd_a_data,
  input  logic [4:0]               rd_b_idx,
  output logic [XLEN-1:0]          rd_b_data,
  input  logic                     wr_en,
  input  logic [4:0]               wr_idx,
  input  logic [XLEN-1:0]          wr_data,
  input  logic                     call_en,
  input  logic [XLEN-1:0]          call_pc,
  input  logic                     save_req,
  input  logic                     restore_req,
  input  logic                     alt_glb,
  output logic [$clog2(NWIN)-1:0]  cwp_o,
  output logic                     ovf_o,
  output logic                     unf_o
);

  localparam int CW   = $clog2(NWIN);
  localparam int PHYS = 2 * GLB_REGS + SET_REGS * NWIN;
  localparam int PW   = $clog2(PHYS);
  localparam int NRD  = 2;

  logic [CW-1:0] cwp;
  logic [CW-1:0] depth;

  rwf_window_ctrl #(.NWIN(NWIN), .CW(CW)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .save_req    (save_req),
    .restore_req (restore_req),
    .cwp         (cwp),
    .depth       (depth),
    .ovf         (ovf_o),
    .unf         (unf_o)
  );

  assign cwp_o = cwp;

  // Read side: one mapper per port.
  logic [NRD-1:0][4:0]      rd_idx;
  logic [NRD-1:0][PW-1:0]   rd_pidx;
  logic [NRD-1:0]           rd_zero;
  logic [NRD-1:0][XLEN-1:0] rd_raw;

  assign rd_idx[0] = rd_a_idx;
  assign rd_idx[1] = rd_b_idx;

  for (genvar g = 0; g < NRD; g++) begin : g_rmap
    rwf_addr_map #(.NWIN(NWIN), .CW(CW), .PW(PW)) u_rmap (
      .lidx    (rd_idx[g]),
      .cwp     (cwp),
      .alt     (alt_glb),
      .pidx    (rd_pidx[g]),
      .is_zero (rd_zero[g])
    );
  end

  assign rd_a_data = rd_zero[0] ? '0 : rd_raw[0];
  assign rd_b_data = rd_zero[1] ? '0 : rd_raw[1];

  // Write side: a call takes the port over an ordinary write.
  logic [4:0]      w_lidx;
  logic [XLEN-1:0] w_data;
  logic            w_req;
  logic [PW-1:0]   w_pidx;
  logic            w_zero;
  logic            w_go;

  always_comb begin
    w_lidx = call_en ? LINK_IDX : wr_idx;
    w_data = call_en ? call_pc  : wr_data;
    w_req  = call_en | wr_en;
  end

  rwf_addr_map #(.NWIN(NWIN), .CW(CW), .PW(PW)) u_wmap (
    .lidx    (w_lidx),
    .cwp     (cwp),
    .alt     (alt_glb),
    .pidx    (w_pidx),
    .is_zero (w_zero)
  );

  assign w_go = w_req & ~w_zero;

  rwf_storage #(.XLEN(XLEN), .PHYS(PHYS), .PW(PW), .NRD(NRD)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (w_go),
    .waddr (w_pidx),
    .wdata (w_data),
    .raddr (rd_pidx),
    .rdata (rd_raw)
  );

endmodule

// File: rtl/rwf_regfile_chk.sv
module rwf_regfile_chk #(
  parameter int XLEN = 64,
  parameter int NWIN = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [4:0]              rd_a_idx,
  input logic [XLEN-1:0]         rd_a_data,
  input logic [4:0]              rd_b_idx,
  input logic [XLEN-1:0]         rd_b_data,
  input logic                    save_req,
  input logic                    restore_req,
  input logic [$clog2(NWIN)-1:0] cwp_o,
  input logic [$clog2(NWIN)-1:0] depth,
  input logic                    ovf_o,
  input logic                    unf_o
);

  localparam int CW = $clog2(NWIN);
  localparam logic [CW-1:0] LAST     = CW'(NWIN - 1);
  localparam logic [CW-1:0] SAVE_MAX = CW'(NWIN - 2);

  // R1: register 0 reads zero on both ports
  a_r1_zero_a: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_idx == 5'd0) |-> (rd_a_data == '0));
  a_r1_zero_b: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_b_idx == 5'd0) |-> (rd_b_data == '0));

  // R4: accepted save steps the pointer down with wrap
  a_r4_save_step: assert property (@(posedge clk) disable iff (!rst_n)
    (save_req && !restore_req && depth < SAVE_MAX) |=>
      (cwp_o == (($past(cwp_o) == '0) ? LAST : CW'($past(cwp_o) - 1'b1))));

  // R4: accepted restore steps the pointer up with wrap
  a_r4_restore_step: assert property (@(posedge clk) disable iff (!rst_n)
    (restore_req && !save_req && depth != '0) |=>
      (cwp_o == (($past(cwp_o) == LAST) ? '0 : CW'($past(cwp_o) + 1'b1))));

  // R8: refused save raises the flag and freezes the pointer
  a_r8_ovf_raise: assert property (@(posedge clk) disable iff (!rst_n)
    (save_req && !restore_req && depth == SAVE_MAX) |=> (ovf_o && cwp_o == $past(cwp_o)));
  a_r8_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= SAVE_MAX);

  // R9: refused restore raises the flag and freezes the pointer
  a_r9_unf_raise: assert property (@(posedge clk) disable iff (!rst_n)
    (restore_req && !save_req && depth == '0) |=> (unf_o && cwp_o == $past(cwp_o)));

  // R10: clashing commands do nothing
  a_r10_clash_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (save_req && restore_req) |=> (!ovf_o && !unf_o && cwp_o == $past(cwp_o)));

endmodule

bind rwin_regfile rwf_regfile_chk #(.XLEN(XLEN), .NWIN(NWIN)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rd_a_idx    (rd_a_idx),
  .rd_a_data   (rd_a_data),
  .rd_b_idx    (rd_b_idx),
  .rd_b_data   (rd_b_data),
  .save_req    (save_req),
  .restore_req (restore_req),
  .cwp_o       (cwp_o),
  .depth       (depth),
  .ovf_o       (ovf_o),
  .unf_o       (unf_o)
);

// File: tb/sim_rwin_regfile.sv
`timescale 1ns/1ps
module sim_rwin_regfile;

  localparam int XLEN = 64;
  localparam int NWIN = 8;
  localparam int CW   = $clog2(NWIN);

  logic            clk = 1'b0;
  logic            rst_n;
  logic [4:0]      rd_a_idx, rd_b_idx, wr_idx;
  logic [XLEN-1:0] rd_a_data, rd_b_data, wr_data, call_pc;
  logic            wr_en, call_en, save_req, restore_req, alt_glb;
  logic [CW-1:0]   cwp_o;
  logic            ovf_o, unf_o;

  always #5 clk = ~clk;

  rwin_regfile #(.XLEN(XLEN), .NWIN(NWIN)) u0 (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .call_en(call_en), .call_pc(call_pc),
    .save_req(save_req), .restore_req(restore_req), .alt_glb(alt_glb),
    .cwp_o(cwp_o), .ovf_o(ovf_o), .unf_o(unf_o)
  );

  int checks = 0;
  int fails  = 0;
  int mcwp   = 0;
  logic [XLEN-1:0] m_glb [2][8];
  logic [XLEN-1:0] m_win [NWIN][16];   // per window: ins 0..7, locals 8..15

  // Reference model built from R1, R2, R5, R6.
  function automatic logic [XLEN-1:0] mexp(input logic [4:0] idx, input logic alt);
    int w;
    case (idx[4:3])
      2'd0: return (idx == 5'd0) ? '0 : m_glb[alt][idx[2:0]];
      2'd1: begin w = (mcwp + NWIN - 1) % NWIN; return m_win[w][idx[2:0]]; end
      2'd2: return m_win[mcwp][8 + idx[2:0]];
      default: return m_win[mcwp][idx[2:0]];
    endcase
  endfunction

  task automatic mset(input logic [4:0] idx, input logic alt, input logic [XLEN-1:0] v);
    int w;
    case (idx[4:3])
      2'd0: if (idx != 5'd0) m_glb[alt][idx[2:0]] = v;
      2'd1: begin w = (mcwp + NWIN - 1) % NWIN; m_win[w][idx[2:0]] = v; end
      2'd2: m_win[mcwp][8 + idx[2:0]] = v;
      default: m_win[mcwp][idx[2:0]] = v;
    endcase
  endtask

  task automatic chk(input string tag, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [4:0] idx, input logic [XLEN-1:0] v);
    wr_en = 1'b1; wr_idx = idx; wr_data = v;
    tick();
    wr_en = 1'b0;
    mset(idx, alt_glb, v);
  endtask

  task automatic rd_chk(input string tag, input logic [4:0] idx);
    rd_a_idx = idx; rd_b_idx = idx;
    #1;
    chk({tag, " portA"}, rd_a_data, mexp(idx, alt_glb));
    chk({tag, " portB"}, rd_b_data, mexp(idx, alt_glb));
  endtask

  task automatic do_save(input string tag, input bit ok);
    save_req = 1'b1;
    tick();
    save_req = 1'b0;
    if (ok) mcwp = (mcwp + NWIN - 1) % NWIN;
    chk({tag, " cwp"}, XLEN'(cwp_o), XLEN'(mcwp));
    chk({tag, " ovf"}, XLEN'(ovf_o), XLEN'(!ok));
    if (!ok) begin
      tick();
      chk({tag, " ovf pulse ends"}, XLEN'(ovf_o), '0);
    end
  endtask

  task automatic do_restore(input string tag, input bit ok);
    restore_req = 1'b1;
    tick();
    restore_req = 1'b0;
    if (ok) mcwp = (mcwp + 1) % NWIN;
    chk({tag, " cwp"}, XLEN'(cwp_o), XLEN'(mcwp));
    chk({tag, " unf"}, XLEN'(unf_o), XLEN'(!ok));
    if (!ok) begin
      tick();
      chk({tag, " unf pulse ends"}, XLEN'(unf_o), '0);
    end
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // R12: reset state
  task automatic t_reset();
    chk("R12 cwp", XLEN'(cwp_o), '0);
    chk("R12 ovf", XLEN'(ovf_o), '0);
    chk("R12 unf", XLEN'(unf_o), '0);
    rd_chk("R12 reg5", 5'd5);
    rd_chk("R12 reg20", 5'd20);
    rd_chk("R12 reg30", 5'd30);
  endtask

  // R1: zero register
  task automatic t_zero();
    alt_glb = 1'b0;
    wr_en = 1'b1; wr_idx = 5'd0; wr_data = 64'hDEAD_BEEF_0000_0001;
    tick(); wr_en = 1'b0;
    rd_chk("R1 zero normal bank", 5'd0);
    alt_glb = 1'b1;
    wr_en = 1'b1; wr_idx = 5'd0; wr_data = 64'hDEAD_BEEF_0000_0002;
    tick(); wr_en = 1'b0;
    rd_chk("R1 zero alt bank", 5'd0);
    alt_glb = 1'b0;
  endtask

  // R2: two independent global banks
  task automatic t_globals();
    alt_glb = 1'b0; wr(5'd3, 64'hAAAA_0000_0000_0003);
    alt_glb = 1'b1; wr(5'd3, 64'hBBBB_0000_0000_0003);
    rd_chk("R2 alt bank g3", 5'd3);
    alt_glb = 1'b0;
    rd_chk("R2 normal bank g3", 5'd3);
    wr(5'd7, 64'h7777);
    alt_glb = 1'b1;
    rd_chk("R2 alt bank g7 untouched", 5'd7);
    alt_glb = 1'b0;
  endtask

  // R3: read during write returns old data
  task automatic t_rdw();
    wr(5'd5, 64'h0505_0505);
    rd_a_idx = 5'd5;
    wr_en = 1'b1; wr_idx = 5'd5; wr_data = 64'hC0FF_EE00_1234_5678;
    #1;
    chk("R3 old value same cycle", rd_a_data, 64'h0505_0505);
    tick(); wr_en = 1'b0;
    mset(5'd5, 1'b0, 64'hC0FF_EE00_1234_5678);
    chk("R3 new value next cycle", rd_a_data, 64'hC0FF_EE00_1234_5678);
  endtask

  // R4, R5, R6: one save/restore round trip
  task automatic t_windows();
    for (int i = 0; i < 8; i++) begin
      wr(5'(8 + i), 64'h1000 + 64'(i));
      wr(5'(16 + i), 64'h2000 + 64'(i));
    end
    do_save("R4 save wraps 0 to NWIN-1", 1'b1);
    chk("R4 wrapped pointer", XLEN'(cwp_o), XLEN'(NWIN - 1));
    for (int i = 0; i < 8; i++) rd_chk("R5 callee ins", 5'(24 + i));
    rd_chk("R6 fresh locals", 5'd16);
    rd_chk("R6 fresh locals", 5'd23);
    for (int i = 0; i < 8; i++) wr(5'(24 + i), 64'h3000 + 64'(i));
    wr(5'd18, 64'h4444);
    do_restore("R4 restore back to 0", 1'b1);
    for (int i = 0; i < 8; i++) rd_chk("R5 caller outs", 5'(8 + i));
    for (int i = 0; i < 8; i++) rd_chk("R6 caller locals kept", 5'(16 + i));
  endtask

  // R7: call writes link register, ordinary write dropped
  task automatic t_call();
    wr(5'd9, 64'h9999);
    wr_en = 1'b1; wr_idx = 5'd9; wr_data = 64'hBAD0;
    call_en = 1'b1; call_pc = 64'h0000_4000_0000_1F04;
    tick();
    wr_en = 1'b0; call_en = 1'b0;
    mset(5'd15, 1'b0, 64'h0000_4000_0000_1F04);
    rd_chk("R7 link register", 5'd15);
    rd_chk("R7 write ignored", 5'd9);
  endtask

  // R8, R9: depth limits with a chain of shared values
  task automatic t_limits();
    for (int k = 0; k < NWIN - 2; k++) begin
      wr(5'd8, 64'h5000 + 64'(k));
      do_save("R8 save within limit", 1'b1);
      rd_chk("R8 chain ins", 5'd24);
    end
    do_save("R8 save refused", 1'b0);
    rd_chk("R8 ins unchanged after refusal", 5'd24);
    for (int k = 0; k < NWIN - 2; k++) begin
      do_restore("R9 restore within limit", 1'b1);
      rd_chk("R9 chain outs", 5'd8);
    end
    do_restore("R9 restore refused", 1'b0);
  endtask

  // R10: both commands at once
  task automatic t_clash();
    save_req = 1'b1; restore_req = 1'b1;
    tick();
    save_req = 1'b0; restore_req = 1'b0;
    chk("R10 cwp held", XLEN'(cwp_o), XLEN'(mcwp));
    chk("R10 no ovf", XLEN'(ovf_o), '0);
    chk("R10 no unf", XLEN'(unf_o), '0);
    do_restore("R10 nothing was saved", 1'b0);
  endtask

  // R11: write with a save lands in the old window
  task automatic t_wr_save();
    wr_en = 1'b1; wr_idx = 5'd10; wr_data = 64'hFACE_0011;
    save_req = 1'b1;
    tick();
    wr_en = 1'b0; save_req = 1'b0;
    mset(5'd10, 1'b0, 64'hFACE_0011);
    mcwp = (mcwp + NWIN - 1) % NWIN;
    chk("R11 cwp moved", XLEN'(cwp_o), XLEN'(mcwp));
    rd_chk("R11 value as callee in", 5'd26);
    do_restore("R11 back", 1'b1);
    rd_chk("R11 caller out", 5'd10);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    report();
  end

  initial begin
    for (int a = 0; a < 2; a++) for (int i = 0; i < 8; i++) m_glb[a][i] = '0;
    for (int w = 0; w < NWIN; w++) for (int i = 0; i < 16; i++) m_win[w][i] = '0;
    rst_n = 1'b0;
    rd_a_idx = '0; rd_b_idx = '0; wr_idx = '0; wr_data = '0; call_pc = '0;
    wr_en = 1'b0; call_en = 1'b0; save_req = 1'b0; restore_req = 1'b0; alt_glb = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_zero();
    t_globals();
    t_rdw();
    t_windows();
    t_call();
    t_limits();
    t_clash();
    t_wr_save();
    report();
  end

endmodule